// File: doc/BRIEF.md
# Fill-and-Carry Left Shift Register

This block holds a 32-bit data word and moves it toward higher bit positions by a programmable count whenever a shift is triggered. Each low-order position that the move leaves empty takes the value of a single fill input, and the last bit pushed past the top of the active width is kept on a carry output. A width select chooses whether the whole 32-bit word takes part, or only the low 16 bits while the upper half is held.

Shifts are triggered in one of two ways. In level mode a shift happens on every clock while the enable is high. In pulse mode a shift happens once for each 0-to-1 change of the enable. A count that is zero or larger than the active width sets an error flag and leaves the word and the carry as they were. A synchronous load port writes a new word and takes priority over any shift requested in the same cycle.

Top module: `fill_shift_unit`

## Requirements
- R1: After reset, data_q is 0, carry_out is 0 and count_err is 0.
- R2: When load_en is 1 at a clock edge, data_q takes load_data on that edge; any shift request in the same cycle is dropped, and carry_out and count_err keep their values.
- R3: With wide = 0, a valid shift by N moves bits 15..0 up by N, fills bits N-1..0 with fill_bit, and holds bits 31..16.
- R4: With wide = 1, a valid shift by N moves all 32 bits up by N and fills bits N-1..0 with fill_bit.
- R5: After a valid shift by N, carry_out holds the old bit (W-N), where W is 16 for wide = 0 and 32 for wide = 1.
- R6: A triggered shift with count = 0 or count > W sets count_err to 1 and leaves data_q and carry_out unchanged.
- R7: A triggered shift with a legal count clears count_err; a cycle with no triggered shift and no load leaves data_q, carry_out and count_err unchanged.
- R8: With edge_mode = 0, every clock with shift_en = 1 performs one shift, so k clocks of enable give k shifts.
- R9: With edge_mode = 1, a shift happens only in a cycle where shift_en is 1 and was 0 in the previous cycle; holding shift_en high gives a single shift.
- R10: A shift by the full active width makes every active bit equal to fill_bit and puts the old bit 0 on carry_out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| load_en | input | 1 | Write load_data into the register |
| load_data | input | 32 | Word to load |
| wide | input | 1 | 1: 32-bit operation, 0: 16-bit operation |
| edge_mode | input | 1 | 1: shift on enable rising edge, 0: shift while enable is high |
| shift_en | input | 1 | Shift enable |
| shift_cnt | input | 6 | Shift count N |
| fill_bit | input | 1 | Value written into vacated low bits |
| data_q | output | 32 | Register contents |
| carry_out | output | 1 | Last bit shifted out of the active top |
| count_err | output | 1 | Set by an out-of-range count on a triggered shift |

## Verification
Every piece of state here is visible at the ports within one clock: a wrong shift result or fill value shows on data_q on the edge after the trigger, and a wrong carry selection shows on carry_out at the same time. A stale enable history in pulse mode shows as an extra or missing shift on the first clock after the enable edge, while a bad range check shows as count_err disagreeing with the count one cycle after the request. Error and carry retention across loads and idle cycles is observed by reading them after sequences that should not touch them.

// File: rtl/fill_shift_pkg.sv
`timescale 1ns/1ps
// Package fill_shift_pkg
// Shared sizes for the fill-and-carry shift unit. Assumes the narrow
// width divides evenly into the full width and both are powers of two.
package fill_shift_pkg;
    localparam int FS_DATA_W   = 32;
    localparam int FS_NARROW_W = 16;
    localparam int FS_CNT_W    = $clog2(FS_DATA_W) + 1;
    localparam int FS_N_LANES  = 2;
endpackage

// File: rtl/fill_shift_trigger.sv
`timescale 1ns/1ps
// Module fill_shift_trigger
// Turns the raw enable into a one-cycle shift request. In level mode
// the request follows the enable; in pulse mode it is raised only in
// the cycle where the enable rises. Assumes enable is synchronous.
module fill_shift_trigger (
    input  logic clk,
    input  logic rst_n,
    input  logic edge_mode,
    input  logic shift_en,
    output logic fire
);
    logic en_prev;

    // Remember last cycle's enable for rising-edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_prev <= 1'b0;
        end else begin
            en_prev <= shift_en;
        end
    end

    // Select level or rising-edge request.
    always_comb begin
        if (edge_mode) begin
            fire = shift_en & ~en_prev;
        end else begin
            fire = shift_en;
        end
    end
endmodule

// File: rtl/fill_shift_range.sv
`timescale 1ns/1ps
// Module fill_shift_range
// Decides whether a shift count is legal for the chosen width: it must
// be at least one and at most the active width. Purely combinational.
module fill_shift_range #(
    parameter int DATA_W   = fill_shift_pkg::FS_DATA_W,
    parameter int NARROW_W = fill_shift_pkg::FS_NARROW_W,
    parameter int CNT_W    = fill_shift_pkg::FS_CNT_W
) (
    input  logic             wide,
    input  logic [CNT_W-1:0] cnt,
    output logic             cnt_ok
);
    localparam logic [CNT_W-1:0] LIM_WIDE   = CNT_W'(DATA_W);
    localparam logic [CNT_W-1:0] LIM_NARROW = CNT_W'(NARROW_W);

    logic [CNT_W-1:0] limit;

    // Pick the limit and compare the count against both ends.
    always_comb begin
        limit  = wide ? LIM_WIDE : LIM_NARROW;
        cnt_ok = (cnt != '0) && (cnt <= limit);
    end
endmodule

// File: rtl/fill_shift_lane.sv
`timescale 1ns/1ps
// Module fill_shift_lane
// Shifts a LANE_W-bit slice up by cnt, filling vacated bits with the
// fill bit, and reports the bit leaving the top last (old bit
// LANE_W-cnt). Output is only meaningful for 1 <= cnt <= LANE_W; the
// caller guards it with the range check.
module fill_shift_lane #(
    parameter int LANE_W = fill_shift_pkg::FS_NARROW_W,
    parameter int CNT_W  = fill_shift_pkg::FS_CNT_W
) (
    input  logic [LANE_W-1:0] din,
    input  logic [CNT_W-1:0]  cnt,
    input  logic              fill,
    output logic [LANE_W-1:0] dout,
    output logic              carry
);
    localparam int IDX_W = $clog2(LANE_W);

    // Per-bit source select: fill below cnt, shifted data above.
    always_comb begin
        for (int i = 0; i < LANE_W; i++) begin
            int src;
            src = i - int'(cnt);
            if (src < 0) begin
                dout[i] = fill;
            end else begin
                dout[i] = din[IDX_W'(src)];
            end
        end
    end

    // Carry is the old bit at LANE_W - cnt when that index is in range.
    always_comb begin
        int ci;
        ci = LANE_W - int'(cnt);
        if (ci >= 0 && ci < LANE_W) begin
            carry = din[IDX_W'(ci)];
        end else begin
            carry = 1'b0;
        end
    end
endmodule

// File: rtl/fill_shift_unit.sv
`timescale 1ns/1ps
// Module fill_shift_unit
// Top of the fill-and-carry left shift register. Holds a DATA_W word,
// loads it synchronously, and on a triggered shift moves either the
// low NARROW_W bits or the whole word up by shift_cnt. Illegal counts
// set count_err and block the shift. Reset is synchronous, active low.
module fill_shift_unit #(
    parameter int DATA_W   = fill_shift_pkg::FS_DATA_W,
    parameter int NARROW_W = fill_shift_pkg::FS_NARROW_W,
    parameter int CNT_W    = fill_shift_pkg::FS_CNT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_en,
    input  logic [DATA_W-1:0] load_data,
    input  logic              wide,
    input  logic              edge_mode,
    input  logic              shift_en,
    input  logic [CNT_W-1:0]  shift_cnt,
    input  logic              fill_bit,
    output logic [DATA_W-1:0] data_q,
    output logic              carry_out,
    output logic              count_err
);
    localparam int N_LANES = fill_shift_pkg::FS_N_LANES;

    logic              fire;
    logic              cnt_ok;
    logic [DATA_W-1:0] lane_word  [N_LANES];
    logic              lane_carry [N_LANES];
    logic [DATA_W-1:0] next_word;
    logic              next_carry;
    logic [DATA_W-1:0] word_r;
    logic              carry_r;
    logic              err_r;

    fill_shift_trigger u_trig (
        .clk       (clk),
        .rst_n     (rst_n),
        .edge_mode (edge_mode),
        .shift_en  (shift_en),
        .fire      (fire)
    );

    fill_shift_range #(
        .DATA_W   (DATA_W),
        .NARROW_W (NARROW_W),
        .CNT_W    (CNT_W)
    ) u_range (
        .wide   (wide),
        .cnt    (shift_cnt),
        .cnt_ok (cnt_ok)
    );

    // One shifter per supported width; lane 0 is narrow, lane 1 full.
    for (genvar g = 0; g < N_LANES; g++) begin : g_lane
        localparam int LW = (g == 0) ? NARROW_W : DATA_W;
        logic [LW-1:0] lane_out;
        logic          lane_c;

        fill_shift_lane #(
            .LANE_W (LW),
            .CNT_W  (CNT_W)
        ) u_lane (
            .din   (word_r[LW-1:0]),
            .cnt   (shift_cnt),
            .fill  (fill_bit),
            .dout  (lane_out),
            .carry (lane_c)
        );

        if (LW < DATA_W) begin : g_pad
            assign lane_word[g] = {word_r[DATA_W-1:LW], lane_out};
        end else begin : g_full
            assign lane_word[g] = lane_out;
        end
        assign lane_carry[g] = lane_c;
    end

    // Choose the lane result matching the width select.
    always_comb begin
        next_word  = wide ? lane_word[1]  : lane_word[0];
        next_carry = wide ? lane_carry[1] : lane_carry[0];
    end

    // Register update: load first, then a legal shift, then error capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_r  <= '0;
            carry_r <= 1'b0;
            err_r   <= 1'b0;
        end else if (load_en) begin
            word_r <= load_data;
        end else if (fire) begin
            if (cnt_ok) begin
                word_r  <= next_word;
                carry_r <= next_carry;
                err_r   <= 1'b0;
            end else begin
                err_r <= 1'b1;
            end
        end
    end

    assign data_q    = word_r;
    assign carry_out = carry_r;
    assign count_err = err_r;
endmodule

// File: rtl/fill_shift_unit_chk.sv
`timescale 1ns/1ps
// Module fill_shift_unit_chk
// Port-level properties of fill_shift_unit, bound to every instance.
module fill_shift_unit_chk #(
    parameter int DATA_W   = fill_shift_pkg::FS_DATA_W,
    parameter int NARROW_W = fill_shift_pkg::FS_NARROW_W,
    parameter int CNT_W    = fill_shift_pkg::FS_CNT_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              load_en,
    input logic [DATA_W-1:0] load_data,
    input logic              wide,
    input logic              edge_mode,
    input logic              shift_en,
    input logic [CNT_W-1:0]  shift_cnt,
    input logic              fill_bit,
    input logic [DATA_W-1:0] data_q,
    input logic              carry_out,
    input logic              count_err
);
    logic             prev_en_c;
    logic [CNT_W-1:0] lim_c;
    logic             bad_c;

    // Checker-side copy of the previous enable, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_en_c <= 1'b0;
        else        prev_en_c <= shift_en;
    end

    always_comb begin
        lim_c = wide ? CNT_W'(DATA_W) : CNT_W'(NARROW_W);
        bad_c = (shift_cnt == '0) || (shift_cnt > lim_c);
    end

    assert_load_wins_R2: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> data_q == $past(load_data));

    assert_upper_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_en && !wide) |=> data_q[DATA_W-1:NARROW_W] == $past(data_q[DATA_W-1:NARROW_W]));

    assert_fill_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_en && !edge_mode && shift_en && !bad_c) |=> (data_q[0] == $past(fill_bit)) && !count_err);

    assert_bad_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_en && !edge_mode && shift_en && bad_c) |=> count_err && $stable(data_q) && $stable(carry_out));

    assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_en && !shift_en) |=> $stable(data_q) && $stable(carry_out) && $stable(count_err));

    assert_pulse_once_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_en && edge_mode && shift_en && prev_en_c) |=> $stable(data_q) && $stable(count_err));
endmodule

bind fill_shift_unit fill_shift_unit_chk #(
    .DATA_W   (DATA_W),
    .NARROW_W (NARROW_W),
    .CNT_W    (CNT_W)
) u_chk (.*);

// File: tb/tb_fill_shift_unit.sv
`timescale 1ns/1ps
module tb_fill_shift_unit;
    typedef struct packed {
        logic [31:0] init;
        logic        wide;
        logic [5:0]  n;
        logic        fill;
        logic [31:0] exp_d;
        logic        exp_c;
        logic        exp_e;
    } vec_t;

    // Applied in order; carry/error expectations depend on the previous row.
    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        '{32'h0000_32F0, 1'b0, 6'd4,  1'b1, 32'h0000_2F0F, 1'b1, 1'b0}, // R3 R5
        '{32'h8000_0001, 1'b1, 6'd1,  1'b0, 32'h0000_0002, 1'b1, 1'b0}, // R4 R5
        '{32'hABCD_8001, 1'b0, 6'd16, 1'b1, 32'hABCD_FFFF, 1'b1, 1'b0}, // R10
        '{32'h1234_5678, 1'b1, 6'd32, 1'b0, 32'h0000_0000, 1'b0, 1'b0}, // R10
        '{32'h0000_1234, 1'b0, 6'd0,  1'b1, 32'h0000_1234, 1'b0, 1'b1}, // R6
        '{32'h0000_1234, 1'b0, 6'd17, 1'b1, 32'h0000_1234, 1'b0, 1'b1}, // R6
        '{32'h0000_FFFF, 1'b1, 6'd8,  1'b0, 32'h00FF_FF00, 1'b0, 1'b0}, // R4 R7
        '{32'hFFFF_8000, 1'b0, 6'd1,  1'b0, 32'hFFFF_0000, 1'b1, 1'b0}, // R3
        '{32'h0000_0001, 1'b1, 6'd33, 1'b0, 32'h0000_0001, 1'b1, 1'b1}, // R6
        '{32'hF000_0000, 1'b1, 6'd4,  1'b1, 32'h0000_000F, 1'b1, 1'b0}, // R4
        '{32'h5555_AAAA, 1'b0, 6'd2,  1'b0, 32'h5555_AAA8, 1'b0, 1'b0}  // R3
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic        load_en;
    logic [31:0] load_data;
    logic        wide;
    logic        edge_mode;
    logic        shift_en;
    logic [5:0]  shift_cnt;
    logic        fill_bit;
    logic [31:0] data_q;
    logic        carry_out;
    logic        count_err;

    int n_chk  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    fill_shift_unit dut (
        .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_data(load_data),
        .wide(wide), .edge_mode(edge_mode), .shift_en(shift_en),
        .shift_cnt(shift_cnt), .fill_bit(fill_bit),
        .data_q(data_q), .carry_out(carry_out), .count_err(count_err)
    );

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic load_word(input logic [31:0] w);
        load_en   = 1'b1;
        load_data = w;
        step();
        load_en   = 1'b0;
    endtask

    initial begin
        #(200000 * 20);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; load_en = 1'b0; load_data = '0; wide = 1'b0;
        edge_mode = 1'b0; shift_en = 1'b0; shift_cnt = '0; fill_bit = 1'b0;
        step(); step();
        rst_n = 1'b1;
        step();
        check("R1 data", data_q, 32'h0);
        check("R1 carry", {31'b0, carry_out}, 32'h0);
        check("R1 err", {31'b0, count_err}, 32'h0);

        // Vector table: load, one level-mode shift, compare.
        for (int v = 0; v < NV; v++) begin
            wide      = VECS[v].wide;
            shift_cnt = VECS[v].n;
            fill_bit  = VECS[v].fill;
            load_word(VECS[v].init);
            shift_en = 1'b1;
            step();
            shift_en = 1'b0;
            check($sformatf("R3/R4 data vec%0d", v), data_q, VECS[v].exp_d);
            check($sformatf("R5 carry vec%0d", v), {31'b0, carry_out}, {31'b0, VECS[v].exp_c});
            check($sformatf("R6/R7 err vec%0d", v), {31'b0, count_err}, {31'b0, VECS[v].exp_e});
        end

        // R8: level mode, three clocks of enable give three shifts.
        wide = 1'b1; shift_cnt = 6'd1; fill_bit = 1'b0; edge_mode = 1'b0;
        load_word(32'h0000_0001);
        shift_en = 1'b1;
        step(); step(); step();
        shift_en = 1'b0;
        check("R8 level triple shift", data_q, 32'h0000_0008);

        // R9: pulse mode, held enable gives one shift; a new edge gives another.
        edge_mode = 1'b1;
        load_word(32'h0000_0001);
        shift_en = 1'b1;
        step(); step(); step();
        check("R9 held enable single shift", data_q, 32'h0000_0002);
        shift_en = 1'b0;
        step();
        shift_en = 1'b1;
        step();
        shift_en = 1'b0;
        check("R9 second edge", data_q, 32'h0000_0004);

        // R2: load beats a shift in the same cycle, carry/err untouched.
        edge_mode = 1'b0; shift_cnt = 6'd4;
        load_en = 1'b1; load_data = 32'hCAFE_0000; shift_en = 1'b1;
        step();
        load_en = 1'b0; shift_en = 1'b0;
        check("R2 load priority", data_q, 32'hCAFE_0000);
        check("R2 err kept", {31'b0, count_err}, 32'h0);

        // R7: error held while idle, cleared by a legal shift.
        shift_cnt = 6'd0; shift_en = 1'b1;
        step();
        shift_en = 1'b0;
        check("R6 error set", {31'b0, count_err}, 32'h1);
        shift_cnt = 6'd3;
        step(); step();
        check("R7 idle keeps err", {31'b0, count_err}, 32'h1);
        check("R7 idle keeps data", data_q, 32'hCAFE_0000);
        shift_en = 1'b1;
        step();
        shift_en = 1'b0;
        check("R7 legal shift clears err", {31'b0, count_err}, 32'h0);
        check("R4 shift by 3", data_q, 32'h57F0_0000);
        check("R5 carry by 3", {31'b0, carry_out}, 32'h0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule